// File: doc/BRIEF.md
# PRBS-7 Built-In Self-Test Pattern Generator and Checker

This block gives a serial link a built-in self-test that needs no external equipment. While the test enable is high, a 7-bit linear feedback shift register produces a maximal-length pseudorandom sequence with a period of 127 bits. The block emits 20 of these bits on every word clock, as two 10-bit chunks. They replace the line-coded word that would otherwise go to the serializer input register. The 8b/10b encoder is bypassed, so the pattern reaches the line as raw bits. It then travels the rest of the transmit path like normal traffic and can be looped back or sent to a far-end receiver.

On the receive side, a checker takes the deserialized 20-bit words and locks onto the incoming sequence by itself. It does not need to be aligned to the generator. It reports pass only after a run of clean words. While the test is enabled, that pass/fail result is driven onto the low-byte K-indication output in place of the normal K flag. When the test is disabled, the transmit word passes through unchanged and the K flag is forwarded unchanged.

Top module: `prbs_selftest`

## Requirements
- R1: During and after reset with the test disabled, `txWordOut` reads 0 until the first clock edge after reset is released, and `rxKLowOut` equals `rxKLowIn`.
- R2: With `testEn` low, `txWordOut` takes the value of `txWordIn` one clock edge later.
- R3: With `testEn` high, each edge loads `txWordOut` with the next 20 bits of the recurrence b[n] = b[n-7] XOR b[n-6], which corresponds to x^7 + x^6 + 1. Bit 0 is the earliest bit in time, and the seven bits before the first word are all ones. `txWordIn` is ignored.
- R4: The generated stream repeats every 127 bits, so the word 127 edges after enabling equals the first word.
- R5: While `testEn` is high, `rxKLowOut` shows the checker pass flag (1 = pass) and ignores `rxKLowIn`. While `testEn` is low, `rxKLowOut` follows `rxKLowIn` combinationally.
- R6: The first word accepted after `testEn` rises only loads the checker history. Pass rises on the edge that accepts the 32nd consecutive error-free word after that first word, and not earlier.
- R7: Any received bit that differs from the value the recurrence predicts from the preceding received bits marks the word as bad. Pass drops on that edge, and a new run of 32 clean words is needed before pass returns.
- R8: An all-zero received word that the checker examines counts as a bad word.
- R9: Driving `testEn` low resets the checker and reseeds the generator. After re-enabling, the first generated word is again the word from the all-ones seed, and pass is low.
- R10: The checker synchronises to any starting phase of the incoming sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testEn | input | 1 | Self-test enable |
| txWordIn | input | 20 | Line-coded word from the encoders (two 10-bit chunks) |
| rxWordIn | input | 20 | Deserialized received word, bit 0 earliest |
| rxKLowIn | input | 1 | Normal low-byte K indication from the decoder |
| txWordOut | output | 20 | Word to the serializer input register |
| rxKLowOut | output | 1 | Low-byte K indication, or the test pass flag while enabled |

## Verification
The transmit word is registered, so a change of `testEn` or `txWordIn` shows up on `txWordOut` one edge later. The bench drives inputs on the falling edge and compares against its own model of the 127-bit sequence at the next falling edge. The pass flag is also registered, so the edge that accepts the 32nd clean word (edge 33 after enabling) is the first one after which pass is checked high, and edge 32 is checked low. A bad word is checked to clear pass right after the edge that consumes it. The output mux is combinational, so the K-flag forwarding is checked within the same half cycle in which the bench changes `testEn` or `rxKLowIn`.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  // Register length and the two delays of the recurrence b[n] = b[n-7] ^ b[n-6]
  localparam int PRBS_ORDER = 7;
  localparam int TAP_FAR    = 7;
  localparam int TAP_NEAR   = 6;

  typedef struct packed {
    logic genRun;    // generator advancing and overriding the transmit word
    logic chkArmed;  // checker history is valid; compare received bits
  } strobes_t;
endpackage

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int CHUNK_W = 10,
  parameter int CHUNKS  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    strobes,
  input  logic [CHUNK_W*CHUNKS-1:0]   txWordIn,
  input  logic [CHUNK_W*CHUNKS-1:0]   rxWordIn,
  output logic [CHUNK_W*CHUNKS-1:0]   txWordOut,
  output logic                        wordErr
);
  localparam int WORD_W = CHUNK_W * CHUNKS;
  localparam int ORD    = PRBS_ORDER;
  localparam logic [ORD-1:0] SEED = '1;

  // History registers: bit 0 is the newest bit, bit k is k+1 bits back
  logic [ORD-1:0]    genHist, genHistNext, chkHist, chkHistNext;
  logic [WORD_W-1:0] genBits, txNext, missBits;

  // Generator: unroll WORD_W steps of the recurrence
  always_comb begin
    logic [ORD-1:0] h;
    logic           nb;
    h = genHist;
    genBits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nb = h[TAP_FAR-1] ^ h[TAP_NEAR-1];
      genBits[i] = nb;
      h = {h[ORD-2:0], nb};
    end
    genHistNext = h;
  end

  // Per-chunk override of the line-coded word
  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunkMux
    assign txNext[c*CHUNK_W +: CHUNK_W] = strobes.genRun ?
      genBits[c*CHUNK_W +: CHUNK_W] : txWordIn[c*CHUNK_W +: CHUNK_W];
  end

  // Checker: predict each bit from received history, then shift in the received bit
  always_comb begin
    logic [ORD-1:0] h;
    h = chkHist;
    missBits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      missBits[i] = (h[TAP_FAR-1] ^ h[TAP_NEAR-1]) != rxWordIn[i];
      h = {h[ORD-2:0], rxWordIn[i]};
    end
    chkHistNext = h;
  end

  assign wordErr = strobes.chkArmed && ((|missBits) || (rxWordIn == '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genHist   <= SEED;
      chkHist   <= SEED;
      txWordOut <= '0;
    end else begin
      genHist   <= strobes.genRun ? genHistNext : SEED;
      chkHist   <= chkHistNext;
      txWordOut <= txNext;
    end
  end
endmodule

// File: rtl/prbs_control.sv
module prbs_control
  import prbs_pkg::*;
#(
  parameter int PASS_WORDS = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     testEn,
  input  logic     wordErr,
  output strobes_t strobes,
  output logic     passOk
);
  localparam int CNT_W = $clog2(PASS_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PASS_WORDS);

  logic             primed;
  logic [CNT_W-1:0] goodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed  <= 1'b0;
      goodCnt <= '0;
    end else if (!testEn) begin
      primed  <= 1'b0;
      goodCnt <= '0;
    end else begin
      primed <= 1'b1;
      if (primed) begin
        if (wordErr)               goodCnt <= '0;
        else if (goodCnt != CNT_FULL) goodCnt <= goodCnt + 1'b1;
      end
    end
  end

  assign strobes.genRun   = testEn;
  assign strobes.chkArmed = primed;
  assign passOk           = (goodCnt == CNT_FULL);
endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
  import prbs_pkg::*;
#(
  parameter int CHUNK_W    = 10,
  parameter int CHUNKS     = 2,
  parameter int PASS_WORDS = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      testEn,
  input  logic [CHUNK_W*CHUNKS-1:0] txWordIn,
  input  logic [CHUNK_W*CHUNKS-1:0] rxWordIn,
  input  logic                      rxKLowIn,
  output logic [CHUNK_W*CHUNKS-1:0] txWordOut,
  output logic                      rxKLowOut
);
  localparam int WORD_W = CHUNK_W * CHUNKS;

  strobes_t strobes;
  logic     wordErr;
  logic     passOk;

  prbs_control #(.PASS_WORDS(PASS_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .testEn(testEn), .wordErr(wordErr),
    .strobes(strobes), .passOk(passOk)
  );

  prbs_datapath #(.CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txWordIn(txWordIn),
    .rxWordIn(rxWordIn), .txWordOut(txWordOut), .wordErr(wordErr)
  );

  assign rxKLowOut = testEn ? passOk : rxKLowIn;
endmodule

// File: rtl/prbs_selftest_chk.sv
module prbs_selftest_chk #(
  parameter int WORD_W     = 20,
  parameter int PASS_WORDS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              testEn,
  input logic [WORD_W-1:0] txWordIn,
  input logic [WORD_W-1:0] txWordOut,
  input logic [WORD_W-1:0] rxWordIn,
  input logic              rxKLowOut,
  input logic              wordErr,
  input logic              chkArmed
);
  localparam int RUN_W = $clog2(PASS_WORDS + 1);

  // Independent count of clean words since the last bad word or disable
  logic [RUN_W-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 runCnt <= '0;
    else if (!testEn)          runCnt <= '0;
    else if (chkArmed) begin
      if (wordErr)             runCnt <= '0;
      else if (runCnt != RUN_W'(PASS_WORDS)) runCnt <= runCnt + 1'b1;
    end
  end

  // R2
  passthru_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> txWordOut == $past(txWordIn));

  // R3
  prbs_continuity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(testEn) && $past(testEn, 2)) |->
      txWordOut[0] == ($past(txWordOut[WORD_W-7]) ^ $past(txWordOut[WORD_W-6])));

  // R6
  pass_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && rxKLowOut) |-> runCnt == RUN_W'(PASS_WORDS));

  // R7
  err_drops_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && wordErr) |=> (!testEn || !rxKLowOut));

  // R8
  zero_word_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkArmed && rxWordIn == '0) |-> wordErr);

  // R9
  disable_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> !chkArmed);
endmodule

bind prbs_selftest prbs_selftest_chk #(.WORD_W(WORD_W), .PASS_WORDS(PASS_WORDS)) u_selftestChk (
  .clk(clk), .rstN(rstN), .testEn(testEn), .txWordIn(txWordIn),
  .txWordOut(txWordOut), .rxWordIn(rxWordIn), .rxKLowOut(rxKLowOut),
  .wordErr(wordErr), .chkArmed(strobes.chkArmed)
);

// File: tb/test_prbs_selftest.sv
`timescale 1ns/1ps
module test_prbs_selftest;
  localparam int W   = 20;
  localparam int OFF = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         testEn = 1'b0;
  logic [W-1:0] txWordIn = '0;
  logic [W-1:0] rxWordIn = '0;
  logic         rxKLowIn = 1'b0;
  logic [W-1:0] txWordOut;
  logic         rxKLowOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;
  logic seqBits [127];
  logic [W-1:0] firstWord;

  always #2 clk = ~clk;

  prbs_selftest i_prbs_selftest (
    .clk(clk), .rstN(rstN), .testEn(testEn), .txWordIn(txWordIn),
    .rxWordIn(rxWordIn), .rxKLowIn(rxKLowIn),
    .txWordOut(txWordOut), .rxKLowOut(rxKLowOut)
  );

  // {rxKLowIn, txWordIn} vectors for the disabled path; output must echo them
  localparam logic [W:0] VEC [6] = '{
    21'h0_00000, 21'h1_FFFFF, 21'h0_A5A5A, 21'h1_5A5A5, 21'h0_12345, 21'h1_80001
  };

  function automatic logic [W-1:0] refWord(int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = seqBits[(W*k + i) % 127];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int n = 0; n < 127; n++) begin
      logic a, b;
      a = (n >= 7) ? seqBits[n-7] : 1'b1;
      b = (n >= 6) ? seqBits[n-6] : 1'b1;
      seqBits[n] = a ^ b;
    end
  end

  initial begin
    // R1: reset state
    rxKLowIn = 1'b1;
    repeat (3) @(negedge clk);
    check(txWordOut == '0, "R1 txWordOut in reset", txWordOut, '0);
    check(rxKLowOut == 1'b1, "R1 K flag forwarded", W'(rxKLowOut), W'(1));
    rstN = 1'b1;
    @(negedge clk);

    // R2/R5: disabled path from the vector table
    foreach (VEC[v]) begin
      txWordIn = VEC[v][W-1:0];
      rxKLowIn = VEC[v][W];
      #1;
      check(rxKLowOut == VEC[v][W], "R5 K flag follows input when disabled",
            W'(rxKLowOut), W'(VEC[v][W]));
      @(posedge clk); @(negedge clk);
      check(txWordOut == VEC[v][W-1:0], "R2 pass-through word", txWordOut, VEC[v][W-1:0]);
    end

    // R3/R4/R6/R7/R8/R10: generator and checker together
    testEn   = 1'b1;
    rxKLowIn = 1'b1;
    rxWordIn = refWord(OFF);
    for (int k = 0; k < 130; k++) begin
      int m;
      txWordIn = W'(k * 32'h9E37 + 32'h1234);
      @(posedge clk); @(negedge clk);
      m = k + 1;
      check(txWordOut == refWord(k), "R3 generated word", txWordOut, refWord(k));
      if (k == 0) firstWord = txWordOut;
      if (k == 127) check(txWordOut == firstWord, "R4 period of 127 bits", txWordOut, firstWord);
      if (m == 32) check(rxKLowOut == 1'b0, "R6 no pass before 32 clean words", W'(rxKLowOut), W'(0));
      if (m == 33) check(rxKLowOut == 1'b1, "R6 R10 pass after 32 clean words", W'(rxKLowOut), W'(1));
      if (m == 40) check(rxKLowOut == 1'b0, "R7 single bit error drops pass", W'(rxKLowOut), W'(0));
      if (m == 71) check(rxKLowOut == 1'b0, "R7 still failing after 31 clean words", W'(rxKLowOut), W'(0));
      if (m == 72) check(rxKLowOut == 1'b1, "R7 pass regained", W'(rxKLowOut), W'(1));
      if (m == 75) check(rxKLowOut == 1'b0, "R8 all-zero word is bad", W'(rxKLowOut), W'(0));
      if (m == 39)      rxWordIn = refWord(OFF + m) ^ W'(1);
      else if (m == 74) rxWordIn = '0;
      else              rxWordIn = refWord(OFF + m);
    end

    // R5/R9: disable, then re-enable
    testEn   = 1'b0;
    rxKLowIn = 1'b0;
    txWordIn = 20'h5A5A5;
    #1;
    check(rxKLowOut == 1'b0, "R5 K flag restored on disable", W'(rxKLowOut), W'(0));
    @(posedge clk); @(negedge clk);
    check(txWordOut == 20'h5A5A5, "R2 pass-through after test", txWordOut, 20'h5A5A5);
    testEn   = 1'b1;
    rxWordIn = refWord(0);
    #1;
    check(rxKLowOut == 1'b0, "R5 R9 checker restarted, input K ignored", W'(rxKLowOut), W'(0));
    @(posedge clk); @(negedge clk);
    check(txWordOut == refWord(0), "R9 generator reseeded", txWordOut, refWord(0));
    check(rxKLowOut == 1'b0, "R9 pass low after re-enable", W'(rxKLowOut), W'(0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule